// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling software. It has one dedicated cycle counter and a parameterised set of 32-bit event counters. Each event counter watches one line of a wide event bus, and an 8-bit type code chosen per counter picks the line. Software programs and reads the unit through a flat register port. Writes take effect at the next rising clock edge. Reads are combinational from the current register state.

Enables and interrupt masks each have a pair of registers, one that sets bits and one that clears them, so software never has to read before it writes. Event counters sit behind a select register and two shared access registers. The cycle counter has its own access register, an optional divide-by-64 prescaler, and its own reset strobe. Every counter that wraps sets a sticky overflow flag, and software clears a flag by writing 1 to it. A single interrupt line reports any overflow whose interrupt is enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all counts, enables, interrupt enables, overflow flags and the select register are zero, irq_o is low, and control (address 0) reads 0x2000 with the default of four counters.
- R2: While control bit 0 (the global enable) is 0, no counter advances, including the cycle counter.
- R3: Event counter n advances by one on each clock edge at which the global enable is set, enable bit n is set, and event_i[type] is high. Here type is the counter's 8-bit code, written at address 9. A disabled counter, or one whose selected line is low, holds its value.
- R4: The enable-set and enable-clear registers are addresses 1 and 2, and the interrupt-enable-set and interrupt-enable-clear registers are addresses 3 and 4. Bit n stands for event counter n and bit 31 for the cycle counter. A 1 written to a set register sets that enable, and a 1 written to a clear register clears it. Bits written as 0 change nothing. Both registers of a pair read back the current enables, with unimplemented bits reading 0.
- R5: Writing control with bit 1 set zeroes every event counter. Writing control with bit 2 set zeroes only the cycle counter and its prescaler. Neither bit is stored, and both read back as 0.
- R6: When control bit 3 is set, the cycle counter (address 7) advances once every 64 enabled cycles. The first step comes on the 64th enabled edge after a cycle-counter reset.
- R7: While control bit 5 is set and dbg_prohibit_i is high, the cycle counter holds. Control bit 4 is stored and read back, and has no other effect.
- R8: Only control bits 0, 3, 4 and 5 hold state. Bits 15:11 read the number of event counters, and every other bit reads 0.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its bit in the overflow register (address 5). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: irq_o is high exactly while some overflow flag is set and the matching interrupt enable bit is also set.
- R11: The select register (address 6, 5 bits) names the event counter reached through the count register (address 8) and the type register (address 9). An index at or above the number of counters makes both registers read 0, and writes to them are ignored.
- R12: A write to the count register, the type register (low 8 bits kept) or the cycle count register loads that value at the next edge. Such a write takes precedence over counting at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| event_i | input | NUM_EVT (256) | Event lines, one per type code |
| dbg_prohibit_i | input | 1 | Debug-prohibit indication that can stop the cycle counter |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
Assertions check on every cycle that:
- a counter whose run condition is false holds, and one whose run condition is true never moves by more than one;
- the cycle counter holds between prescaler terminal counts;
- wraps land in the overflow register, write-1 clears empty their bits, and set/clear writes reach the enable register;
- the interrupt cannot drop without a flag or mask write;
- the control identity field is always present, and out-of-range selects read zero.

Only the bench scenarios show the actual counts. These include the exact step on the 64th prescaled cycle, the debug stop, the event-line choice made by the type code, the reach of the two reset strobes, and the interrupt mask applied to the cycle counter's overflow.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CW = 32;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_IE_CLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_CYC    = 4'd7,
    A_EVCNT  = 4'd8,
    A_EVTYPE = 4'd9
  } reg_addr_e;

  // control bit positions
  localparam int B_EN  = 0;
  localparam int B_EVR = 1;
  localparam int B_CYR = 2;
  localparam int B_DIV = 3;
  localparam int B_EXP = 4;
  localparam int B_DP  = 5;
  localparam int CYC_BIT = 31;
endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
  parameter int CW      = 32,
  parameter int EVT_W   = 8,
  parameter int NUM_EVT = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_vec_i,
  input  logic               clr_i,
  input  logic               cnt_we_i,
  input  logic               type_we_i,
  input  logic [CW-1:0]      cnt_wdata_i,
  input  logic [EVT_W-1:0]   type_wdata_i,
  output logic [CW-1:0]      cnt_o,
  output logic [EVT_W-1:0]   type_o,
  output logic               wrap_o
);
  localparam int EVT_SPACE = 2 ** EVT_W;

  logic [CW-1:0]        cnt_q;
  logic [EVT_W-1:0]     type_q;
  logic [EVT_SPACE-1:0] evt_pad;
  logic                 inc;

  generate
    if (NUM_EVT < EVT_SPACE) begin : g_pad
      assign evt_pad = {{(EVT_SPACE-NUM_EVT){1'b0}}, evt_vec_i};
    end else begin : g_full
      assign evt_pad = evt_vec_i;
    end
  endgenerate

  assign inc    = run_i & evt_pad[type_q];
  assign wrap_o = inc & ~cnt_we_i & ~clr_i & (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      if (cnt_we_i)   cnt_q <= cnt_wdata_i;
      else if (clr_i) cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + CW'(1);
      if (type_we_i)  type_q <= type_wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i && !clr_i) |=> $stable(cnt_q));

  p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int CW    = 32,
  parameter int PRE_W = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          div_i,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0]    cnt_q;
  logic [PRE_W-1:0] presc_q;
  logic             tick;

  assign tick   = run_i & (~div_i | (presc_q == {PRE_W{1'b1}}));
  assign wrap_o = tick & ~we_i & ~clr_i & (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else begin
      if (clr_i)      presc_q <= '0;
      else if (run_i) presc_q <= presc_q + PRE_W'(1);
      if (we_i)       cnt_q <= wdata_i;
      else if (clr_i) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_prescale_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && !we_i && !clr_i && presc_q != {PRE_W{1'b1}}) |=> $stable(cnt_q));

  p_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 256,
  parameter int EVT_W   = 8,
  parameter int SEL_W   = 5,
  parameter int PRE_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         reg_addr_i,
  input  logic               reg_we_i,
  input  logic [CW-1:0]      reg_wdata_i,
  output logic [CW-1:0]      reg_rdata_o,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               dbg_prohibit_i,
  output logic               irq_o
);
  localparam logic [CW-1:0] EV_MASK    = (CW'(1) << NUM_CTR) - CW'(1);
  localparam logic [CW-1:0] VALID_MASK = EV_MASK | (CW'(1) << CYC_BIT);
  localparam logic [4:0]    NUM_CTR_F  = 5'(NUM_CTR);

  logic ctrl_en_q, ctrl_div_q, ctrl_exp_q, ctrl_dp_q;
  logic [CW-1:0]    en_q, ie_q, ovf_q;
  logic [SEL_W-1:0] sel_q;

  logic wr_ctrl, wr_enset, wr_enclr, wr_ieset, wr_ieclr, wr_ovf, wr_sel, wr_cyc, wr_evcnt, wr_evtype;
  logic evt_clr, cyc_clr, cyc_run;
  logic [CW-1:0]    wrap_v;
  logic [CW-1:0]    ev_cnt  [NUM_CTR];
  logic [EVT_W-1:0] ev_type [NUM_CTR];
  logic [CW-1:0]    cyc_cnt, sel_cnt;
  logic [EVT_W-1:0] sel_type;

  assign wr_ctrl   = reg_we_i & (reg_addr_i == A_CTRL);
  assign wr_enset  = reg_we_i & (reg_addr_i == A_EN_SET);
  assign wr_enclr  = reg_we_i & (reg_addr_i == A_EN_CLR);
  assign wr_ieset  = reg_we_i & (reg_addr_i == A_IE_SET);
  assign wr_ieclr  = reg_we_i & (reg_addr_i == A_IE_CLR);
  assign wr_ovf    = reg_we_i & (reg_addr_i == A_OVF);
  assign wr_sel    = reg_we_i & (reg_addr_i == A_SEL);
  assign wr_cyc    = reg_we_i & (reg_addr_i == A_CYC);
  assign wr_evcnt  = reg_we_i & (reg_addr_i == A_EVCNT);
  assign wr_evtype = reg_we_i & (reg_addr_i == A_EVTYPE);

  assign evt_clr = wr_ctrl & reg_wdata_i[B_EVR];
  assign cyc_clr = wr_ctrl & reg_wdata_i[B_CYR];
  assign cyc_run = ctrl_en_q & en_q[CYC_BIT] & ~(ctrl_dp_q & dbg_prohibit_i);

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      pmu_event_ctr #(.CW(CW), .EVT_W(EVT_W), .NUM_EVT(NUM_EVT)) u_ctr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (ctrl_en_q & en_q[i]),
        .evt_vec_i    (event_i),
        .clr_i        (evt_clr),
        .cnt_we_i     (wr_evcnt & (sel_q == SEL_W'(i))),
        .type_we_i    (wr_evtype & (sel_q == SEL_W'(i))),
        .cnt_wdata_i  (reg_wdata_i),
        .type_wdata_i (reg_wdata_i[EVT_W-1:0]),
        .cnt_o        (ev_cnt[i]),
        .type_o       (ev_type[i]),
        .wrap_o       (wrap_v[i])
      );
    end
    for (genvar k = NUM_CTR; k < CYC_BIT; k++) begin : g_nowrap
      assign wrap_v[k] = 1'b0;
    end
  endgenerate

  pmu_cycle_ctr #(.CW(CW), .PRE_W(PRE_W)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cyc_run),
    .div_i   (ctrl_div_q),
    .clr_i   (cyc_clr),
    .we_i    (wr_cyc),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cyc_cnt),
    .wrap_o  (wrap_v[CYC_BIT])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_div_q <= 1'b0;
      ctrl_exp_q <= 1'b0;
      ctrl_dp_q  <= 1'b0;
      en_q       <= '0;
      ie_q       <= '0;
      ovf_q      <= '0;
      sel_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en_q  <= reg_wdata_i[B_EN];
        ctrl_div_q <= reg_wdata_i[B_DIV];
        ctrl_exp_q <= reg_wdata_i[B_EXP];
        ctrl_dp_q  <= reg_wdata_i[B_DP];
      end
      if (wr_enset) en_q <= (en_q | reg_wdata_i) & VALID_MASK;
      if (wr_enclr) en_q <= en_q & ~reg_wdata_i;
      if (wr_ieset) ie_q <= (ie_q | reg_wdata_i) & VALID_MASK;
      if (wr_ieclr) ie_q <= ie_q & ~reg_wdata_i;
      // a wrap in the same cycle as a clear keeps the flag
      ovf_q <= ((ovf_q & ~(wr_ovf ? reg_wdata_i : '0)) | wrap_v) & VALID_MASK;
      if (wr_sel) sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    sel_cnt  = '0;
    sel_type = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_cnt  = ev_cnt[i];
        sel_type = ev_type[i];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_EN]  = ctrl_en_q;
        reg_rdata_o[B_DIV] = ctrl_div_q;
        reg_rdata_o[B_EXP] = ctrl_exp_q;
        reg_rdata_o[B_DP]  = ctrl_dp_q;
        reg_rdata_o[15:11] = NUM_CTR_F;
      end
      A_EN_SET, A_EN_CLR: reg_rdata_o = en_q;
      A_IE_SET, A_IE_CLR: reg_rdata_o = ie_q;
      A_OVF:    reg_rdata_o = ovf_q;
      A_SEL:    reg_rdata_o[SEL_W-1:0] = sel_q;
      A_CYC:    reg_rdata_o = cyc_cnt;
      A_EVCNT:  reg_rdata_o = sel_cnt;
      A_EVTYPE: reg_rdata_o[EVT_W-1:0] = sel_type;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & ie_q);

  p_wrap_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_v != '0) |=> ((ovf_q & $past(wrap_v)) == $past(wrap_v)));

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ovf && wrap_v == '0) |=> ((ovf_q & $past(reg_wdata_i)) == '0));

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_ovf && !wr_ieclr) |=> irq_o);

  p_en_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enset |=> ((en_q & $past(reg_wdata_i & VALID_MASK)) == $past(reg_wdata_i & VALID_MASK)));

  p_en_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enclr |=> ((en_q & $past(reg_wdata_i)) == '0));

  p_ctrl_id_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTRL) |-> (reg_rdata_o[15:11] == NUM_CTR_F && reg_rdata_o[2:1] == 2'b00));

  p_sel_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_EVCNT && {{(32-SEL_W){1'b0}}, sel_q} >= 32'(NUM_CTR)) |-> (reg_rdata_o == '0));
endmodule

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;
  localparam int NV = 39;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] ev = '0;
  logic         dbg = 1'b0;
  logic         irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev),
    .dbg_prohibit_i(dbg), .irq_o(irq)
  );

  // {req, write, addr, data}: a read row carries the expected value
  localparam logic [40:0] VT [0:NV-1] = '{
    {4'd1, 1'b0, 4'd0, 32'h0000_2000},  // R1 control id
    {4'd1, 1'b0, 4'd1, 32'h0},          // R1
    {4'd1, 1'b0, 4'd5, 32'h0},          // R1
    {4'd1, 1'b0, 4'd7, 32'h0},          // R1
    {4'd8, 1'b1, 4'd0, 32'hFFFF_FFFF},  // R8 writable bits only
    {4'd8, 1'b0, 4'd0, 32'h0000_2039},  // R8
    {4'd8, 1'b1, 4'd0, 32'h0},
    {4'd8, 1'b0, 4'd0, 32'h0000_2000},
    {4'd4, 1'b1, 4'd1, 32'hFFFF_FFFF},  // R4 set pair
    {4'd4, 1'b0, 4'd1, 32'h8000_000F},
    {4'd4, 1'b0, 4'd2, 32'h8000_000F},
    {4'd4, 1'b1, 4'd2, 32'h0000_0005},
    {4'd4, 1'b0, 4'd1, 32'h8000_000A},
    {4'd4, 1'b1, 4'd2, 32'h8000_000A},
    {4'd4, 1'b0, 4'd1, 32'h0},
    {4'd4, 1'b1, 4'd3, 32'h8000_0002},
    {4'd4, 1'b0, 4'd4, 32'h8000_0002},
    {4'd4, 1'b1, 4'd4, 32'hFFFF_FFFF},
    {4'd4, 1'b0, 4'd3, 32'h0},
    {4'd12, 1'b1, 4'd6, 32'h2},         // R12 indirect load
    {4'd12, 1'b1, 4'd9, 32'h0000_01AB},
    {4'd12, 1'b0, 4'd9, 32'h0000_00AB},
    {4'd12, 1'b1, 4'd8, 32'h1234_5678},
    {4'd12, 1'b0, 4'd8, 32'h1234_5678},
    {4'd11, 1'b1, 4'd6, 32'h7},         // R11 out-of-range select
    {4'd11, 1'b1, 4'd8, 32'h0000_DEAD},
    {4'd11, 1'b0, 4'd8, 32'h0},
    {4'd11, 1'b0, 4'd9, 32'h0},
    {4'd11, 1'b0, 4'd6, 32'h7},
    {4'd11, 1'b1, 4'd6, 32'h2},
    {4'd11, 1'b0, 4'd8, 32'h1234_5678},
    {4'd12, 1'b1, 4'd7, 32'h55},
    {4'd12, 1'b0, 4'd7, 32'h55},
    {4'd5, 1'b1, 4'd0, 32'h4},          // R5 cycle reset only
    {4'd5, 1'b0, 4'd7, 32'h0},
    {4'd5, 1'b0, 4'd8, 32'h1234_5678},
    {4'd5, 1'b0, 4'd0, 32'h0000_2000},
    {4'd5, 1'b1, 4'd0, 32'h2},          // R5 event reset
    {4'd5, 1'b0, 4'd8, 32'h0}
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.5;
    n_vec++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #0.5;
    n_vec++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VT[i][36]) wr(VT[i][35:32], VT[i][31:0]);
      else chk(VT[i][35:32], VT[i][31:0], $sformatf("R%0d", VT[i][40:37]));
    end

    // R2 / R3: type select and gating
    wr(4'd6, 32'd0); wr(4'd9, 32'd5);
    wr(4'd6, 32'd1); wr(4'd9, 32'd200);
    wr(4'd1, 32'h3);
    ev[5] = 1'b1;
    repeat (3) @(negedge clk);
    ev = '0;
    wr(4'd6, 32'd0);
    chk(4'd8, 32'd0, "R2");
    wr(4'd0, 32'h1);
    ev[5] = 1'b1; ev[200] = 1'b1;
    repeat (2) @(negedge clk);
    ev[200] = 1'b0;
    repeat (2) @(negedge clk);
    ev = '0;
    chk(4'd8, 32'd4, "R3");
    wr(4'd6, 32'd1);
    chk(4'd8, 32'd2, "R3");
    wr(4'd6, 32'd2);
    chk(4'd8, 32'd0, "R3");

    // R9 / R10: event counter wrap
    wr(4'd6, 32'd0);
    wr(4'd8, 32'hFFFF_FFFE);
    ev[5] = 1'b1;
    repeat (2) @(negedge clk);
    ev = '0;
    chk(4'd8, 32'd0, "R9");
    chk(4'd5, 32'h1, "R9");
    chk_irq(1'b0, "R10");
    wr(4'd3, 32'h1);
    chk_irq(1'b1, "R10");
    wr(4'd5, 32'h0);
    chk(4'd5, 32'h1, "R9");
    chk_irq(1'b1, "R10");
    wr(4'd5, 32'h1);
    chk(4'd5, 32'h0, "R9");
    chk_irq(1'b0, "R10");

    // R9: cycle counter wrap, interrupt masked
    wr(4'd1, 32'h8000_0000);
    wr(4'd7, 32'hFFFF_FFFF);
    chk(4'd7, 32'hFFFF_FFFF, "R12");
    @(negedge clk);
    chk(4'd7, 32'h0, "R9");
    chk(4'd5, 32'h8000_0000, "R9");
    chk_irq(1'b0, "R10");
    wr(4'd2, 32'h8000_0000);
    chk(4'd7, 32'd1, "R4");
    wr(4'd5, 32'hFFFF_FFFF);

    // R6: prescaler
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h0000_000D);
    repeat (63) @(negedge clk);
    chk(4'd7, 32'd0, "R6");
    @(negedge clk);
    chk(4'd7, 32'd1, "R6");
    wr(4'd0, 32'h1);
    repeat (10) @(negedge clk);
    chk(4'd7, 32'd11, "R6");

    // R7: debug stop and stored export bit
    wr(4'd0, 32'h31);
    chk(4'd0, 32'h0000_2031, "R7");
    chk(4'd7, 32'd12, "R7");
    dbg = 1'b1;
    repeat (5) @(negedge clk);
    chk(4'd7, 32'd12, "R7");
    dbg = 1'b0;
    repeat (3) @(negedge clk);
    chk(4'd7, 32'd15, "R7");

    // R2: global enable off freezes the cycle counter
    wr(4'd0, 32'h0);
    repeat (5) @(negedge clk);
    chk(4'd7, 32'd16, "R2");

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(4'd7, 32'd0, "R1");
    chk(4'd1, 32'd0, "R1");
    chk(4'd3, 32'd0, "R1");
    chk(4'd6, 32'd0, "R1");
    chk(4'd0, 32'h0000_2000, "R1");
    chk_irq(1'b0, "R1");

    done = 1'b1;
    finish_run();
  end
endmodule